// File: doc/BRIEF.md
# External Interrupt Pin Conditioner

This block conditions one active-low external interrupt line before it reaches the interrupt logic. The raw line is brought into the clock domain through a synchroniser. A small control register then sets how the line is treated. In level mode the request is raised while the line is held low. In edge mode a high-to-low transition sets a sticky pending latch. That latch stays set until reset or until the interrupt is serviced.

The control register is 8 bits wide and uses two of them. One bit chooses level or falling-edge recognition. The other bit connects the line to the interrupt logic or cuts it off. The recognition-mode bit can be written only once after reset, unless the chip is in a special mode. The enable bit can be changed at any time. The block drives a single interrupt request level, which downstream priority and vectoring logic consume.

Top module: `irq_pin_conditioner`

## Requirements
- R1: Register layout: bit 7 is the recognition-mode bit (0 = level, 1 = falling edge) and bit 6 is the pin-enable bit (1 = connected). Bits 5..0 always read 0, and writes to them have no effect. The read data reflects a write from the cycle after the write strobe.
- R2: After reset the register reads 8'h00 and `irq_req` is 0.
- R3: In level mode with the pin enabled, `irq_req` is 1 exactly while the synchronised pin is low. A low on the pin first shows on `irq_req` two rising edges after it is set up.
- R4: In edge mode, a falling edge on the synchronised pin sets the pending latch, and `irq_req` equals enable AND pending. The request shows three rising edges after the pin falls. It stays set after the pin returns high.
- R5: Falling edges are captured in edge mode even while the pin is disabled. Enabling the pin later exposes the captured request.
- R6: When `special_mode` is 0, the first register write locks the recognition-mode bit until reset, and later writes leave it unchanged. When `special_mode` is 1, the bit is writable on every write, and such writes do not lock it.
- R7: The pin-enable bit takes every written value in any mode. While it is 0, `irq_req` is 0.
- R8: A one-cycle `svc_ack` clears the pending latch at that rising edge. If a new falling edge is detected at that same edge, the latch stays set.
- R9: In level mode, falling edges are not captured, so switching to edge mode afterwards raises no request. `svc_ack` has no visible effect in level mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pin_n | input | 1 | Raw asynchronous active-low interrupt line |
| special_mode | input | 1 | 1 while the chip is in a special mode (mode bit freely writable) |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data, always valid |
| svc_ack | input | 1 | Interrupt service acknowledge pulse |
| irq_req | output | 1 | Conditioned interrupt request level |

## Verification
Each result has a fixed delay from its stimulus. Register contents appear one rising edge after the write strobe. A level-mode request appears two rising edges after the pin changes, and an edge-mode request appears three. A service acknowledge takes effect at the edge on which it is held. The bench drives all inputs on falling clock edges and samples outputs on the next falling edge. Directed cases count edges explicitly and check one cycle before the expected change as well as on it. The random phase compares both outputs every cycle against a requirement-level model advanced on the same edges.

// File: rtl/irq_cond_pkg.sv
// Package: shared constants and types for the interrupt pin conditioner.
// Assumes an 8-bit register with the mode bit above the enable bit.
package irq_cond_pkg;
    localparam int CFG_W       = 8;
    localparam int MODE_BIT    = 7;
    localparam int ENABLE_BIT  = 6;
    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        logic edge_mode;
        logic pin_enable;
    } irq_cfg_t;
endpackage

// File: rtl/irq_pin_sync.sv
// Module: irq_pin_sync
// Brings the raw active-low line into the clock domain through a chain of
// STAGES flops. It also keeps one extra delayed sample so that a falling edge
// (1 followed by 0) can be flagged. Assumes STAGES >= 2.
// Reset loads the idle (high) level so that no false edge is reported.
module irq_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw_n,
    output logic pin_sync_n,
    output logic fall_seen
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Shift the raw line through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], pin_raw_n};
    end

    // Hold the previous synchronised sample for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= chain_q[STAGES-1];
    end

    // Report the synchronised level and a high-to-low transition.
    always_comb begin
        pin_sync_n = chain_q[STAGES-1];
        fall_seen  = prev_q & ~chain_q[STAGES-1];
    end
endmodule

// File: rtl/irq_cfg_reg.sv
// Module: irq_cfg_reg
// Control register holding the recognition-mode and pin-enable bits.
// The mode bit is write-once outside special mode, enforced by a lock flag
// that only reset clears. Reserved bits read as zero.
// Assumes the write strobe lasts one cycle per write.
module irq_cfg_reg
    import irq_cond_pkg::*;
#(
    parameter int W      = CFG_W,
    parameter int M_BIT  = MODE_BIT,
    parameter int EN_BIT = ENABLE_BIT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         special_mode,
    output logic [W-1:0] rdata,
    output irq_cfg_t     cfg
);
    irq_cfg_t cfg_q;
    logic     lock_q;
    logic     mode_wr_ok;

    // Decide whether this write may change the mode bit.
    always_comb mode_wr_ok = special_mode | ~lock_q;

    // Update the enable bit on every write, and the mode bit only when permitted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr) begin
            cfg_q.pin_enable <= wdata[EN_BIT];
            if (mode_wr_ok) cfg_q.edge_mode <= wdata[M_BIT];
        end
    end

    // Set the write-once lock on the first write outside special mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                   lock_q <= 1'b0;
        else if (wr && !special_mode) lock_q <= 1'b1;
    end

    // Assemble read data with reserved bits held at zero.
    always_comb begin
        rdata         = '0;
        rdata[M_BIT]  = cfg_q.edge_mode;
        rdata[EN_BIT] = cfg_q.pin_enable;
        cfg           = cfg_q;
    end

    AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && lock_q && !special_mode) |=> $stable(cfg_q.edge_mode)); // R6
    AST_ENABLE_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (cfg_q.pin_enable == $past(wdata[EN_BIT]))); // R7
    AST_SPECIAL_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && special_mode) |=> (cfg_q.edge_mode == $past(wdata[M_BIT]))); // R6
endmodule

// File: rtl/irq_pend_latch.sv
// Module: irq_pend_latch
// Sticky pending flag for edge mode. A detected fall sets it while edge mode
// is selected, regardless of the pin enable. A service acknowledge clears it.
// A new fall at the same edge as the acknowledge wins, so no edge is lost.
module irq_pend_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_mode,
    input  logic fall_seen,
    input  logic ack,
    output logic pending
);
    logic pend_q;
    logic capture;

    // Qualify edges: only capture while falling-edge recognition is chosen.
    always_comb capture = edge_mode & fall_seen;

    // Set on a qualified edge, clear on acknowledge, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend_q <= 1'b0;
        else if (capture) pend_q <= 1'b1;
        else if (ack)     pend_q <= 1'b0;
    end

    // Expose the latch state.
    always_comb pending = pend_q;

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !ack) |=> pend_q); // R4
    AST_EDGE_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && fall_seen) |=> pend_q); // R8
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !(edge_mode && fall_seen)) |=> !pend_q); // R8
endmodule

// File: rtl/irq_pin_conditioner.sv
// Module: irq_pin_conditioner (top)
// Conditions an external active-low interrupt line into a single request
// level. It uses a synchroniser, a configuration register and an edge
// pending latch. Assumes svc_ack is a one-cycle pulse from the interrupt
// service logic and that cfg_wr is a one-cycle strobe.
module irq_pin_conditioner
    import irq_cond_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_pin_n,
    input  logic             special_mode,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             svc_ack,
    output logic             irq_req
);
    irq_cfg_t cfg;
    logic     pin_sync_n;
    logic     fall_seen;
    logic     pending;

    irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_raw_n  (irq_pin_n),
        .pin_sync_n (pin_sync_n),
        .fall_seen  (fall_seen)
    );

    irq_cfg_reg #(.W(CFG_W), .M_BIT(MODE_BIT), .EN_BIT(ENABLE_BIT)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr           (cfg_wr),
        .wdata        (cfg_wdata),
        .special_mode (special_mode),
        .rdata        (cfg_rdata),
        .cfg          (cfg)
    );

    irq_pend_latch u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_mode (cfg.edge_mode),
        .fall_seen (fall_seen),
        .ack       (svc_ack),
        .pending   (pending)
    );

    // Select the request source by mode and gate it with the pin enable.
    always_comb begin
        if (!cfg.pin_enable)    irq_req = 1'b0;
        else if (cfg.edge_mode) irq_req = pending;
        else                    irq_req = ~pin_sync_n;
    end

    AST_RESERVED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (cfg_rdata[ENABLE_BIT-1:0] == '0)); // R1
    AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.edge_mode) |=> ($past(pending) || !pending)); // R9
endmodule

// File: tb/sim_irq_pin_conditioner.sv
// Bench for irq_pin_conditioner: directed corner cases, then seeded random
// stimulus checked against a requirement-level model. Inputs are driven on
// falling edges and outputs are sampled on falling edges.
module sim_irq_pin_conditioner;
    localparam int CLK_PERIOD = 10;
    localparam int RAND_CYCLES = 4000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       irq_pin_n = 1'b1;
    logic       special_mode = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       svc_ack = 1'b0;
    logic       irq_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    irq_pin_conditioner u0 (
        .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n),
        .special_mode(special_mode), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .svc_ack(svc_ack), .irq_req(irq_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Requirement model: two-edge pin delay, edge history, mode lock, latch.
    logic m_s1, m_s2, m_s3, m_edge, m_en, m_lock, m_pend;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= 1; m_s2 <= 1; m_s3 <= 1;
            m_edge <= 0; m_en <= 0; m_lock <= 0; m_pend <= 0;
        end else begin
            m_s1 <= irq_pin_n; m_s2 <= m_s1; m_s3 <= m_s2;
            if (cfg_wr) begin
                m_en <= cfg_wdata[6];
                if (special_mode || !m_lock) m_edge <= cfg_wdata[7];
                if (!special_mode) m_lock <= 1'b1;
            end
            if (m_edge && m_s3 && !m_s2) m_pend <= 1'b1;
            else if (svc_ack)            m_pend <= 1'b0;
        end
    end

    function automatic logic exp_irq();
        return m_en && (m_edge ? m_pend : !m_s2);
    endfunction

    function automatic logic [7:0] exp_rdata();
        return {m_edge, m_en, 6'b000000};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0; cfg_wr = 0; svc_ack = 0; irq_pin_n = 1;
        cyc(2);
        rst_n = 1;
    endtask

    task automatic wr_cfg(input logic [7:0] d);
        cfg_wr = 1; cfg_wdata = d;
        cyc(1);
        cfg_wr = 0;
    endtask

    task automatic pulse_ack();
        svc_ack = 1;
        cyc(1);
        svc_ack = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        cyc(1);
        // R2: reset state
        do_reset();
        cyc(1);
        chk("R2 rdata", cfg_rdata, 8'h00);
        chk("R2 irq", {7'b0, irq_req}, 8'h00);

        // R1: reserved bits ignored; R6: later normal write keeps mode
        wr_cfg(8'hFF);
        chk("R1 readback", cfg_rdata, 8'hC0);
        wr_cfg(8'h00);
        chk("R6 mode locked", cfg_rdata, 8'h80);
        chk("R7 enable written", {7'b0, cfg_rdata[6]}, 8'h00);

        // R6: special mode writes freely and does not lock
        do_reset();
        special_mode = 1;
        wr_cfg(8'h80); chk("R6 special set", cfg_rdata, 8'h80);
        wr_cfg(8'h00); chk("R6 special clear", cfg_rdata, 8'h00);
        special_mode = 0;
        wr_cfg(8'hC0); chk("R6 first normal write", cfg_rdata, 8'hC0);
        wr_cfg(8'h40); chk("R6 second normal write", cfg_rdata, 8'hC0);

        // R3: level mode timing and follow
        do_reset();
        wr_cfg(8'h40);
        irq_pin_n = 0;
        cyc(1); chk("R3 one edge", {7'b0, irq_req}, 8'h00);
        cyc(1); chk("R3 two edges", {7'b0, irq_req}, 8'h01);
        irq_pin_n = 1;
        cyc(2); chk("R3 release", {7'b0, irq_req}, 8'h00);
        // R7: disable gates request
        irq_pin_n = 0; cyc(3);
        wr_cfg(8'h00); chk("R7 disabled", {7'b0, irq_req}, 8'h00);
        irq_pin_n = 1; cyc(3);

        // R4: edge mode timing and stickiness
        do_reset();
        wr_cfg(8'hC0);
        irq_pin_n = 0;
        cyc(2); chk("R4 two edges", {7'b0, irq_req}, 8'h00);
        cyc(1); chk("R4 three edges", {7'b0, irq_req}, 8'h01);
        irq_pin_n = 1;
        cyc(5); chk("R4 sticky", {7'b0, irq_req}, 8'h01);
        // R8: acknowledge clears
        pulse_ack(); chk("R8 ack clears", {7'b0, irq_req}, 8'h00);
        // R8: new fall at same edge as ack keeps it set
        irq_pin_n = 0; cyc(3);
        chk("R8 pend again", {7'b0, irq_req}, 8'h01);
        irq_pin_n = 1; cyc(3);
        irq_pin_n = 0; cyc(2);
        pulse_ack(); chk("R8 simultaneous edge", {7'b0, irq_req}, 8'h01);
        irq_pin_n = 1; cyc(3);

        // R5: capture while disabled
        do_reset();
        special_mode = 1;
        wr_cfg(8'h80);
        irq_pin_n = 0; cyc(4);
        chk("R5 hidden", {7'b0, irq_req}, 8'h00);
        wr_cfg(8'hC0); chk("R5 exposed", {7'b0, irq_req}, 8'h01);

        // R9: level mode does not capture, ack inert
        do_reset();
        wr_cfg(8'h40);
        irq_pin_n = 0; cyc(3);
        pulse_ack(); chk("R9 ack inert", {7'b0, irq_req}, 8'h01);
        irq_pin_n = 1; cyc(3);
        wr_cfg(8'hC0); chk("R9 no capture", {7'b0, irq_req}, 8'h00);
        special_mode = 0;

        // Random phase against the model
        do_reset();
        for (int n = 0; n < RAND_CYCLES; n++) begin
            if (($urandom % 5) == 0) irq_pin_n = ~irq_pin_n;
            special_mode = (($urandom % 4) == 0);
            cfg_wr = (($urandom % 12) == 0);
            cfg_wdata = 8'($urandom);
            svc_ack = (($urandom % 10) == 0);
            if (($urandom % 700) == 0) rst_n = 0; else rst_n = 1;
            cyc(1);
            if (rst_n) begin
                chk(m_edge ? "R4 random irq" : "R3 random irq", {7'b0, irq_req}, {7'b0, exp_irq()});
                chk("R6 random rdata", cfg_rdata, exp_rdata());
            end
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule